// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block lets a chip answer on a two-wire open-drain serial bus as an addressed target. It watches the clock and data lines through a two-flop synchronizer and detects START and STOP conditions. It shifts in the address byte and acknowledges only when the upper seven bits equal a programmable own address. After a match it either receives bytes from the external controller or sends bytes to it, one byte at a time, through a single 8-bit data register on a small register port.

The block never makes the controller wait on a fixed timer. When a received byte is waiting for the host, or when the controller wants a byte the host has not yet supplied, the block holds the clock line low. It lets the line go again once the host has read or written the data register. A first-byte flag tells the host which received byte came straight after the address. Three event bits record START, STOP and data hand-offs. Each event bit has a mask bit, and together they drive a single interrupt line.

Top module: `i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal the own address (register 1, bits 6:0) is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the block ignores the following bytes until the next START or STOP.
- R2: Bit 0 of a write to register 0 enables the target (1) or disables it (0). While disabled, the block drives neither line, acknowledges no address and raises no event.
- R3: After the eighth bit of a received data byte, the block sets receive-request (register 0 read, bit 0), drives the acknowledge and holds SCL low. It releases SCL and clears receive-request one clock after the host reads the data register (register 2).
- R4: The first-byte flag (register 0 read, bit 2) is 1 together with receive-request for the first data byte after the address and 0 for later bytes. A data register read clears it, and it is never 1 while the target transmits.
- R5: When the controller addresses the target for reading (address bit 0 = 1) and after each byte the controller acknowledges, the block sets transmit-request (register 0 read, bit 1) and holds SCL low. One clock after the host writes the data register, it releases SCL and sends that byte MSB first.
- R6: A host write to the data register stores the byte and a later read returns it; a received byte replaces it. The value is otherwise held.
- R7: Raw events (register 3) are bit 0 data hand-off, bit 1 START seen and bit 2 STOP seen. A write of 1 to a bit of the write-only clear register (register 6) clears that raw bit, and a write of 0 leaves it unchanged.
- R8: The mask register (register 4) resets to 0. The masked status (register 5) is raw AND mask, and irq is 1 when any masked bit is 1.
- R9: When the controller does not acknowledge a transmitted byte, the block releases SDA, raises no transmit-request and waits for STOP or a repeated START.
- R10: A repeated START in the middle of a transfer restarts the address phase, so a new address and direction take effect.
- R11: After reset, both line drivers are off, irq is 0 and the status, raw event and mask registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the serial clock line |
| sda_in | input | 1 | Sensed level of the serial data line |
| scl_pull | output | 1 | 1 pulls the clock line low (stretching) |
| sda_pull | output | 1 | 1 pulls the data line low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for data register reads) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | OR of masked events |

## Verification
The bench acts as the external controller and waits on the clock line it shares with the block, so a host that answers late makes the block stretch. A design that fails to stretch shows up as wrong or missing received bytes. The bench checks that the first-byte flag rises on the first byte only, because a design that never reset it per address would flag every byte. A NACKed read byte must not leave the clock held, since a design that ignored the NACK would hang the bus with transmit-request set. The bench also sends a mismatched address and a matching address while disabled, which a careless decoder would acknowledge.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int NEV = 3;
  localparam int EV_DATA  = 0;
  localparam int EV_START = 1;
  localparam int EV_STOP  = 2;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_OWN    = 3'd1;
  localparam logic [2:0] REG_DATA   = 3'd2;
  localparam logic [2:0] REG_RAW    = 3'd3;
  localparam logic [2:0] REG_MASK   = 3'd4;
  localparam logic [2:0] REG_MASKED = 3'd5;
  localparam logic [2:0] REG_CLEAR  = 3'd6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_END, ST_ADDR_ACK,
    ST_RX_BYTE, ST_RX_END, ST_RX_HOLD, ST_RX_ACK,
    ST_TX_WAIT, ST_TX_BYTE, ST_TX_ACK, ST_TX_ACKD,
    ST_WAIT_STOP
  } tgt_state_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;
    always_comb ff_d = {ff_q[STAGES-2:0], d[b]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL}};
      else        ff_q <= ff_d;
    end
    assign q[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    start_p  = scl_q & scl_s & sda_q & ~sda_s;
    stop_p   = scl_q & scl_s & ~sda_q & sda_s;
    scl_rise = ~scl_q & scl_s;
    scl_fall = scl_q & ~scl_s;
  end
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int OWN_W = BYTE_W - 1,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [OWN_W-1:0]  own_addr,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              rreq,
  output logic              treq,
  output logic              fbr,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ev_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_t        state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              first_q, first_d;
  logic              fbr_q, fbr_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    fbr_d   = fbr_q;
    rx_load = 1'b0;
    ev_data = 1'b0;
    if (!en || stop_p) begin
      state_d = ST_IDLE;
      fbr_d   = 1'b0;
    end else if (start_p) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      fbr_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_RX_BYTE: if (scl_rise) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = (state_q == ST_ADDR) ? ST_ADDR_END : ST_RX_END;
        end
        ST_ADDR_END: if (scl_fall) begin
          state_d = (sh_q[BYTE_W-1:1] == own_addr) ? ST_ADDR_ACK : ST_WAIT_STOP;
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (sh_q[0]) begin
            state_d = ST_TX_WAIT;
            ev_data = 1'b1;
          end else begin
            state_d = ST_RX_BYTE;
            cnt_d   = '0;
            first_d = 1'b1;
          end
        end
        ST_RX_END: if (scl_fall) begin
          state_d = ST_RX_HOLD;
          rx_load = 1'b1;
          fbr_d   = first_q;
          ev_data = 1'b1;
        end
        ST_RX_HOLD: if (data_rd) begin
          state_d = ST_RX_ACK;
          fbr_d   = 1'b0;
        end
        ST_RX_ACK: if (scl_fall) begin
          state_d = ST_RX_BYTE;
          cnt_d   = '0;
          first_d = 1'b0;
        end
        ST_TX_WAIT: if (data_wr) begin
          state_d = ST_TX_BYTE;
          sh_d    = wdata;
          cnt_d   = '0;
        end
        ST_TX_BYTE: if (scl_fall) begin
          sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = ST_TX_ACK;
        end
        ST_TX_ACK: if (scl_rise) begin
          state_d = sda_s ? ST_WAIT_STOP : ST_TX_ACKD;
        end
        ST_TX_ACKD: if (scl_fall) begin
          state_d = ST_TX_WAIT;
          ev_data = 1'b1;
        end
        ST_IDLE, ST_WAIT_STOP: state_d = state_q;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      fbr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      fbr_q   <= fbr_d;
    end
  end

  always_comb begin
    rreq     = (state_q == ST_RX_HOLD);
    treq     = (state_q == ST_TX_WAIT);
    fbr      = fbr_q;
    scl_pull = rreq | treq;
    sda_pull = (state_q == ST_ADDR_ACK) | rreq | (state_q == ST_RX_ACK)
             | ((state_q == ST_TX_BYTE) & ~sh_q[BYTE_W-1]);
    rx_byte  = sh_q;
  end
endmodule

// File: rtl/i2ct_evt.sv
module i2ct_evt #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set,
  input  logic           clr_wr,
  input  logic           mask_wr,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] raw,
  output logic [NEV-1:0] mask,
  output logic [NEV-1:0] masked,
  output logic           irq
);
  for (genvar i = 0; i < NEV; i++) begin : g_ev
    logic raw_q, raw_d, mask_q;
    always_comb raw_d = set[i] | (raw_q & ~(clr_wr & wbits[i]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= raw_d;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= 1'b0;
      else if (mask_wr) mask_q <= wbits[i];
    end
    assign raw[i]    = raw_q;
    assign mask[i]   = mask_q;
    assign masked[i] = raw_q & mask_q;
  end
  assign irq = |masked;
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2ct_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int OWN_W      = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0] lines_s;
  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
  logic en_q, own_we, ctrl_we;
  logic [OWN_W-1:0]  own_q;
  logic [BYTE_W-1:0] data_q, data_d, rx_byte;
  logic data_rd, data_wr, clr_wr, mask_wr, rx_load, ev_data, ev_start;
  logic rreq, treq, fbr;
  logic [NEV-1:0] ev_set, raw, mask, masked;

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2ct_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall));

  always_comb begin
    ctrl_we = reg_wr & (reg_addr == REG_CTRL);
    own_we  = reg_wr & (reg_addr == REG_OWN);
    data_wr = reg_wr & (reg_addr == REG_DATA);
    data_rd = reg_rd & (reg_addr == REG_DATA);
    mask_wr = reg_wr & (reg_addr == REG_MASK);
    clr_wr  = reg_wr & (reg_addr == REG_CLEAR);
  end

  i2ct_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .own_addr(own_q),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .data_rd(data_rd), .data_wr(data_wr), .wdata(reg_wdata),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .rreq(rreq), .treq(treq), .fbr(fbr),
    .rx_load(rx_load), .rx_byte(rx_byte), .ev_data(ev_data));

  always_comb begin
    ev_start         = start_p & en_q;
    ev_set           = '0;
    ev_set[EV_DATA]  = ev_data;
    ev_set[EV_START] = ev_start;
    ev_set[EV_STOP]  = stop_p & en_q;
  end

  i2ct_evt #(.NEV(NEV)) u_evt (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr_wr(clr_wr), .mask_wr(mask_wr),
    .wbits(reg_wdata[NEV-1:0]), .raw(raw), .mask(mask), .masked(masked), .irq(irq));

  always_comb data_d = rx_load ? rx_byte : reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      own_q  <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_we)            en_q   <= reg_wdata[0];
      if (own_we)             own_q  <= reg_wdata[OWN_W-1:0];
      if (rx_load || data_wr) data_q <= data_d;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL:   reg_rdata = {{(BYTE_W-3){1'b0}}, fbr, treq, rreq};
      REG_OWN:    reg_rdata = {1'b0, own_q};
      REG_DATA:   reg_rdata = data_q;
      REG_RAW:    reg_rdata = {{(BYTE_W-NEV){1'b0}}, raw};
      REG_MASK:   reg_rdata = {{(BYTE_W-NEV){1'b0}}, mask};
      REG_MASKED: reg_rdata = {{(BYTE_W-NEV){1'b0}}, masked};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       rreq,
  input logic       treq,
  input logic       fbr,
  input logic       en,
  input logic       data_rd,
  input logic       data_wr,
  input logic       clr_wr,
  input logic [2:0] clr_bits,
  input logic       ev_start,
  input logic [2:0] raw
);
  a_r3_hold_on_rreq: assert property (@(posedge clk) disable iff (!rst_n)
    rreq |-> scl_pull);
  a_r3_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rreq && data_rd |=> !rreq && !scl_pull);
  a_r4_fbr_needs_rreq: assert property (@(posedge clk) disable iff (!rst_n)
    fbr |-> rreq);
  a_r5_hold_on_treq: assert property (@(posedge clk) disable iff (!rst_n)
    treq |-> scl_pull);
  a_r5_release_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    treq && data_wr |=> !scl_pull);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_pull && !scl_pull);
  a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_bits[1] && !ev_start |=> !raw[1]);
endmodule

bind i2c_target i2ct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .rreq(rreq), .treq(treq), .fbr(fbr), .en(en_q), .data_rd(data_rd),
  .data_wr(data_wr), .clr_wr(clr_wr), .clr_bits(reg_wdata[2:0]),
  .ev_start(ev_start), .raw(raw));

// File: tb/test_i2c_target.sv
module test_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam logic [2:0] A_CTRL = 3'd0, A_OWN = 3'd1, A_DATA = 3'd2, A_RAW = 3'd3,
                         A_MASK = 3'd4, A_MASKED = 3'd5, A_CLR = 3'd6;
  localparam logic [6:0] MY_ADDR = 7'h5A;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic scl_pull, sda_pull;
  logic reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq;
  wire scl_w = scl_m & ~scl_pull;
  wire sda_w = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  bit bus_done;
  logic [8:0] sb_rx[$];
  logic [7:0] sb_tx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target i_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_w), .sda_in(sda_w),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    while (!scl_w) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; cyc(HALF);
    scl_m = 1'b1; wait_scl_high(); cyc(HALF);
    sda_m = 1'b0; cyc(HALF);
    scl_m = 1'b0; cyc(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; cyc(HALF);
    scl_m = 1'b1; wait_scl_high(); cyc(HALF);
    sda_m = 1'b1; cyc(HALF);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; cyc(HALF);
    scl_m = 1'b1; wait_scl_high(); cyc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; cyc(HALF);
    scl_m = 1'b1; wait_scl_high(); cyc(HALF/2);
    b = sda_w; cyc(HALF/2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(nack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(nack);
  endtask

  // Monitor side of the scoreboard: serves the host port while the bus runs.
  task automatic service();
    logic [7:0] st, d, t;
    logic [8:0] e;
    while (!bus_done) begin
      @(negedge clk);
      peek(A_CTRL, st);
      if (st[0]) begin
        repeat (30) @(negedge clk);
        check(scl_pull == 1'b1, "R3", "SCL held while byte waits", scl_pull, 1);
        e = (sb_rx.size() > 0) ? sb_rx.pop_front() : 9'h1FF;
        peek(A_CTRL, st);
        check(st[2] == e[8], "R4", "first-byte flag", st[2], e[8]);
        host_read(A_DATA, d);
        check(d == e[7:0], "R3", "received byte", d, e[7:0]);
        peek(A_CTRL, st);
        check(st[2:0] == 3'b000, "R4", "flags after data read", st, 0);
        check(scl_pull == 1'b0, "R3", "SCL released after read", scl_pull, 0);
      end else if (st[1]) begin
        check(st[2] == 1'b0, "R4", "no first-byte flag in transmit", st[2], 0);
        repeat (30) @(negedge clk);
        check(scl_pull == 1'b1, "R5", "SCL held while transmit byte missing", scl_pull, 1);
        t = (sb_tx.size() > 0) ? sb_tx.pop_front() : 8'h00;
        host_write(A_DATA, t);
        check(scl_pull == 1'b0, "R5", "SCL released after data write", scl_pull, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung (actual=running expected=finished)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, b;
    logic nk;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    cyc(5);
    @(negedge clk) rst_n = 1'b1;
    cyc(5);
    @(negedge clk);
    // R11 reset state
    check(!scl_pull && !sda_pull, "R11", "lines released at reset", {scl_pull, sda_pull}, 0);
    check(irq == 1'b0, "R11", "irq low at reset", irq, 0);
    peek(A_CTRL, d); check(d == 8'h00, "R11", "status at reset", d, 0);
    peek(A_RAW, d);  check(d == 8'h00, "R11", "raw events at reset", d, 0);
    peek(A_MASK, d); check(d == 8'h00, "R8", "mask at reset", d, 0);

    // R6 host write then read back
    host_write(A_DATA, 8'hC3);
    @(negedge clk); peek(A_DATA, d);
    check(d == 8'hC3, "R6", "data register holds host write", d, 8'hC3);

    host_write(A_OWN, {1'b0, MY_ADDR});
    host_write(A_CTRL, 8'h01);

    // Write transfer: address match, three bytes with stretching
    bus_done = 1'b0;
    fork
      begin
        bus_start();
        send_byte({MY_ADDR, 1'b0}, nk);
        check(nk == 1'b0, "R1", "matching address acked", nk, 0);
        sb_rx.push_back({1'b1, 8'h11}); send_byte(8'h11, nk);
        check(nk == 1'b0, "R3", "byte 1 acked", nk, 0);
        sb_rx.push_back({1'b0, 8'h22}); send_byte(8'h22, nk);
        check(nk == 1'b0, "R3", "byte 2 acked", nk, 0);
        sb_rx.push_back({1'b0, 8'h33}); send_byte(8'h33, nk);
        check(nk == 1'b0, "R3", "byte 3 acked", nk, 0);
        bus_stop();
        bus_done = 1'b1;
      end
      service();
    join
    check(sb_rx.size() == 0, "R3", "all received bytes handed to host", sb_rx.size(), 0);
    @(negedge clk); peek(A_DATA, d);
    check(d == 8'h33, "R6", "data register holds last received byte", d, 8'h33);
    peek(A_RAW, d); check(d == 8'h07, "R7", "raw events after transfer", d, 8'h07);
    check(irq == 1'b0, "R8", "irq low with all masks off", irq, 0);

    // R8 masking, R7 clear
    host_write(A_MASK, 8'h02);
    @(negedge clk);
    check(irq == 1'b1, "R8", "irq with start event unmasked", irq, 1);
    peek(A_MASKED, d); check(d == 8'h02, "R8", "masked status", d, 8'h02);
    host_write(A_CLR, 8'h02);
    @(negedge clk); peek(A_RAW, d);
    check(d == 8'h05, "R7", "only start event cleared", d, 8'h05);
    check(irq == 1'b0, "R8", "irq low after clear", irq, 0);
    host_write(A_CLR, 8'h05);
    @(negedge clk); peek(A_RAW, d); check(d == 8'h00, "R7", "remaining events cleared", d, 0);

    // R1 address mismatch
    bus_start();
    send_byte({MY_ADDR ^ 7'h01, 1'b0}, nk);
    check(nk == 1'b1, "R1", "mismatched address not acked", nk, 1);
    send_byte(8'h77, nk);
    check(nk == 1'b1, "R1", "byte after mismatch ignored", nk, 1);
    bus_stop();
    @(negedge clk); peek(A_DATA, d);
    check(d == 8'h33, "R1", "data unchanged after mismatch", d, 8'h33);
    peek(A_RAW, d); check(d == 8'h06, "R7", "start and stop but no data event", d, 8'h06);
    host_write(A_CLR, 8'h07);

    // Write one byte, repeated START, then read two bytes (second NACKed)
    bus_done = 1'b0;
    fork
      begin
        bus_start();
        send_byte({MY_ADDR, 1'b0}, nk);
        sb_rx.push_back({1'b1, 8'h44}); send_byte(8'h44, nk);
        check(nk == 1'b0, "R3", "byte before repeated start acked", nk, 0);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, nk);
        check(nk == 1'b0, "R10", "read address acked after repeated start", nk, 0);
        sb_tx.push_back(8'hA5); sb_tx.push_back(8'h3C);
        recv_byte(b, 1'b0);
        check(b == 8'hA5, "R5", "first transmitted byte", b, 8'hA5);
        recv_byte(b, 1'b1);
        check(b == 8'h3C, "R5", "second transmitted byte", b, 8'h3C);
        cyc(HALF);
        check(sda_pull == 1'b0 && scl_pull == 1'b0, "R9", "lines free after NACK",
              {scl_pull, sda_pull}, 0);
        peek(A_CTRL, d);
        check(d[1] == 1'b0, "R9", "no transmit request after NACK", d[1], 0);
        bus_stop();
        bus_done = 1'b1;
      end
      service();
    join
    check(sb_tx.size() == 0, "R5", "all transmit bytes consumed", sb_tx.size(), 0);
    host_write(A_CLR, 8'h07);

    // R2 disabled target
    host_write(A_CTRL, 8'h00);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, nk);
    check(nk == 1'b1, "R2", "disabled target does not ack", nk, 1);
    bus_stop();
    @(negedge clk); peek(A_RAW, d);
    check(d == 8'h00, "R2", "no events while disabled", d, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule